// File: doc/BRIEF.md
# Buffered I2C Byte-Transfer Sequencer

This block runs a multi-byte I2C data phase for a host. It sits between a host register port and a byte-level I2C engine that handles bit timing, START/STOP and addressing. The host fills a 68-entry byte buffer through an indirect data port, writes a count/control word, then writes a control register to launch. In transmit mode the block hands the engine one buffered byte at a time until the programmed number of bytes has gone out or the remote side refuses a byte. In receive mode it stores each incoming byte, keeps a running tally in the count register, and tells the engine before every acknowledge slot whether to ACK or NACK.

A buffered launch with a byte count of zero or above 68 moves nothing and raises the interrupt at once. In byte mode the count word is ignored and exactly one byte, buffer entry 0, is moved. The interrupt marks the end of every transfer and stays set until the host clears it. No launch is accepted while it is set.

Top module: `buf_i2c_seq`

## Requirements
- R1: After reset, `irq` and `eng_req` are 0 and the count word reads back as 0x00.
- R2: A buffered launch whose count field (bits 6:0 of the count word) is 0 or greater than 68 never raises `eng_req`. `irq` is 1 in the cycle after the launch write, and the count word is left unchanged.
- R3: A buffered transmit launch with count N presents buffer entries 0 to N-1 in order on `eng_tx_byte`, advancing one entry per `eng_done`. After the N-th `eng_done`, `eng_req` drops and `irq` rises.
- R4: In transmit mode, `eng_nack`=1 together with `eng_done` ends the transfer. `irq` rises, and the count field then holds the number of bytes completed, including the refused one. Bit 7 of the count word is kept.
- R5: A buffered receive launch stores each `eng_rx_byte` into the buffer at entries 0, 1, 2 and so on. The count field tracks the number of bytes stored. `eng_ack` is 1 for every byte except the final one.
- R6: For the final received byte, `eng_ack` equals the inverse of bit 7 of the count word. A value of 1 gives a NACK, and a value of 0 gives an ACK that leaves the read open. In transmit mode bit 7 changes neither the bytes sent nor the end of the transfer.
- R7: Once set, `irq` stays 1 until a control write with bit 3 set. A launch written while `irq` is 1 is refused: `eng_req` stays 0.
- R8: In byte mode (control bit 2 = 0) the count word is neither checked nor changed. Exactly one byte moves using buffer entry 0. In receive, `eng_ack` equals control bit 4.
- R9: Indirect access works as follows. `host_addr`=0 selects the index register. `host_addr`=1 is the data port: index 0x00 reaches the count word and index 0x01 reaches the buffer. Each buffer read or write advances an internal pointer, which a write to the index register resets to 0 and which wraps from 67 back to 0.
- R10: The transfer pointer restarts at buffer entry 0 on every launch.

Control word (`host_addr`=2, write): bit 0 launch, bit 1 receive, bit 2 buffered, bit 3 clear interrupt, bit 4 byte-mode ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (advances the buffer pointer) |
| host_addr | input | 2 | 0 index, 1 data port, 2 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| irq | output | 1 | Transfer-ended interrupt |
| eng_req | output | 1 | A byte is wanted from the engine |
| eng_rx | output | 1 | Current transfer direction, 1 = receive |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_ack | output | 1 | ACK decision for the current received byte |
| eng_done | input | 1 | Engine finished one byte |
| eng_nack | input | 1 | Remote refused the transmitted byte |
| eng_rx_byte | input | 8 | Byte received by the engine |

## Verification
A transfer pointer that starts in the wrong place or skips ahead shows up on `eng_tx_byte` at the very first requested byte. A wrong end condition shows up when `eng_req` stays high or drops, or when `irq` rises one `eng_done` too early or too late. A corrupted byte count or last-byte flag appears as a wrong `eng_ack` on the final received byte, and as a wrong count read back right after the interrupt. Receive storage faults appear only when the host reads the buffer back, so every receive case is followed by a readback of the stored bytes.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int CNT_W = 7;

  // control word bit positions
  localparam int CB_GO  = 0;
  localparam int CB_RX  = 1;
  localparam int CB_BUF = 2;
  localparam int CB_CLR = 3;
  localparam int CB_ACK = 4;
  localparam int CB_W   = 5;

  typedef enum logic {S_IDLE, S_RUN} seq_st_t;

  // legal buffered byte count: 1 .. lim
  function automatic logic count_ok(input logic [CNT_W-1:0] n, input int lim);
    return (n != '0) && (int'(n) <= lim);
  endfunction

  // acknowledge decision for a received byte at index idx of n
  function automatic logic ack_for(input logic [CNT_W-1:0] idx,
                                   input logic [CNT_W-1:0] n,
                                   input logic lb);
    return (idx == n - 1'b1) ? ~lb : 1'b1;
  endfunction
endpackage

// File: rtl/bseq_buffer.sv
module bseq_buffer #(
  parameter int DEPTH = 68,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_wdata,
  output logic [DW-1:0] e_rdata,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // engine side writes last so it wins a same-entry collision
  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
    if (e_we) mem[e_addr] <= e_wdata;
  end

  assign e_rdata = mem[e_addr];
  assign h_rdata = mem[h_addr];
endmodule

// File: rtl/bseq_hostport.sv
module bseq_hostport #(
  parameter int DEPTH = 68,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    idx_q,
  output logic [AW-1:0] hptr,
  output logic          cnt_wr,
  output logic          buf_wr,
  output logic          ctrl_wr
);
  logic sel_idx, sel_data, adv;

  assign sel_idx  = host_addr == 2'd0;
  assign sel_data = host_addr == 2'd1;
  assign cnt_wr   = host_we && sel_data && idx_q == 8'h00;
  assign buf_wr   = host_we && sel_data && idx_q == 8'h01;
  assign adv      = (host_we || host_re) && sel_data && idx_q == 8'h01;
  assign ctrl_wr  = host_we && host_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      hptr  <= '0;
    end else if (host_we && sel_idx) begin
      idx_q <= host_wdata;
      hptr  <= '0;
    end else if (adv) begin
      hptr <= (int'(hptr) == DEPTH - 1) ? '0 : hptr + 1'b1;
    end
  end

  p_hptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hptr) < DEPTH);
  p_hptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && int'(hptr) == DEPTH - 1 && !(host_we && sel_idx)) |=> hptr == '0);
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
  import bseq_pkg::*;
#(
  parameter int DEPTH = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CB_W-1:0]   ctrl_bits,
  input  logic              cnt_wr,
  input  logic [7:0]        cnt_data,
  input  logic              eng_done,
  input  logic              eng_nack,
  output logic              busy,
  output logic              rx,
  output logic [CNT_W-1:0]  ptr,
  output logic [7:0]        count_q,
  output logic              irq,
  output logic              ack_w,
  output logic              store
);
  seq_st_t          st;
  logic             rx_q, bufm_q, bmack_q, lb_q, irq_q;
  logic [CNT_W-1:0] n_q, n_eff;
  logic             final_w, byte_end, launch_try, launch_bad, launch_ok;

  assign busy       = st == S_RUN;
  assign rx         = rx_q;
  assign irq        = irq_q;
  assign n_eff      = bufm_q ? n_q : CNT_W'(1);
  assign final_w    = ptr == n_eff - 1'b1;
  assign ack_w      = bufm_q ? ack_for(ptr, n_q, lb_q) : bmack_q;
  assign store      = busy && eng_done && rx_q;
  assign byte_end   = busy && eng_done && (final_w || (!rx_q && eng_nack));
  assign launch_try = ctrl_wr && ctrl_bits[CB_GO] && !irq_q && !busy;
  assign launch_bad = launch_try && ctrl_bits[CB_BUF] && !count_ok(count_q[CNT_W-1:0], DEPTH);
  assign launch_ok  = launch_try && !launch_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rx_q    <= 1'b0;
      bufm_q  <= 1'b0;
      bmack_q <= 1'b0;
      lb_q    <= 1'b0;
      n_q     <= '0;
      ptr     <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr && ctrl_bits[CB_CLR]) irq_q <= 1'b0;
      if (launch_bad || byte_end)       irq_q <= 1'b1;
      if (cnt_wr && !busy)              count_q <= cnt_data;
      if (launch_ok) begin
        st      <= S_RUN;
        ptr     <= '0;
        rx_q    <= ctrl_bits[CB_RX];
        bufm_q  <= ctrl_bits[CB_BUF];
        bmack_q <= ctrl_bits[CB_ACK];
        n_q     <= count_q[CNT_W-1:0];
        lb_q    <= count_q[7];
        if (ctrl_bits[CB_BUF] && ctrl_bits[CB_RX]) count_q[CNT_W-1:0] <= '0;
      end else if (busy && eng_done) begin
        ptr <= ptr + 1'b1;
        if (bufm_q && (rx_q || byte_end)) count_q[CNT_W-1:0] <= ptr + 1'b1;
        if (byte_end) st <= S_IDLE;
      end
    end
  end

  p_bad_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> (irq_q && !busy));
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(ctrl_wr && ctrl_bits[CB_CLR])) |=> irq_q);
  p_refuse_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[CB_GO] && irq_q && !busy) |=> !busy);
  p_ptr_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ptr == '0);
  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ptr < n_eff);
  p_end_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (irq_q && !busy));
endmodule

// File: rtl/buf_i2c_seq.sv
module buf_i2c_seq
  import bseq_pkg::*;
#(
  parameter int DEPTH = 68,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  output logic       eng_req,
  output logic       eng_rx,
  output logic [7:0] eng_tx_byte,
  output logic       eng_ack,
  input  logic       eng_done,
  input  logic       eng_nack,
  input  logic [7:0] eng_rx_byte
);
  logic [7:0]       idx_q, count_q, h_rdata;
  logic [AW-1:0]    hptr;
  logic [CNT_W-1:0] ptr;
  logic             cnt_wr, buf_wr, ctrl_wr, busy, rx, ack_w, store;

  bseq_hostport #(.DEPTH(DEPTH)) u_host (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .idx_q(idx_q),
    .hptr(hptr), .cnt_wr(cnt_wr), .buf_wr(buf_wr), .ctrl_wr(ctrl_wr)
  );

  bseq_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .ctrl_bits(host_wdata[CB_W-1:0]), .cnt_wr(cnt_wr), .cnt_data(host_wdata),
    .eng_done(eng_done), .eng_nack(eng_nack), .busy(busy), .rx(rx),
    .ptr(ptr), .count_q(count_q), .irq(irq), .ack_w(ack_w), .store(store)
  );

  bseq_buffer #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk(clk), .e_we(store), .e_addr(ptr[AW-1:0]), .e_wdata(eng_rx_byte),
    .e_rdata(eng_tx_byte), .h_we(buf_wr), .h_addr(hptr),
    .h_wdata(host_wdata), .h_rdata(h_rdata)
  );

  assign eng_req = busy;
  assign eng_rx  = rx;
  assign eng_ack = ack_w;

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == 2'd0) host_rdata = idx_q;
    else if (host_addr == 2'd1) begin
      if (idx_q == 8'h00)      host_rdata = count_q;
      else if (idx_q == 8'h01) host_rdata = h_rdata;
    end
  end

  p_no_req_when_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eng_req) |=> !eng_req);
endmodule

// File: tb/sim_buf_i2c_seq.sv
`timescale 1ns/1ps
module sim_buf_i2c_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0, host_re = 0, eng_done = 0, eng_nack = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, eng_rx_byte = 0, host_rdata, eng_tx_byte;
  logic irq, eng_req, eng_rx, eng_ack;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  buf_i2c_seq u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .eng_req(eng_req), .eng_rx(eng_rx), .eng_tx_byte(eng_tx_byte),
    .eng_ack(eng_ack), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rx_byte(eng_rx_byte)
  );

  // {rx, buffered, byte-mode ack, count word, nack index (FF none), bytes moved}
  localparam logic [26:0] TV [13] = '{
    {3'b010, 8'h03, 8'hFF, 8'd3},
    {3'b010, 8'h44, 8'hFF, 8'd68},
    {3'b010, 8'h05, 8'h02, 8'd3},
    {3'b110, 8'h84, 8'hFF, 8'd4},
    {3'b110, 8'h02, 8'hFF, 8'd2},
    {3'b010, 8'h00, 8'hFF, 8'd0},
    {3'b110, 8'h45, 8'hFF, 8'd0},
    {3'b010, 8'hFF, 8'hFF, 8'd0},
    {3'b010, 8'h81, 8'hFF, 8'd1},
    {3'b000, 8'h00, 8'hFF, 8'd1},
    {3'b101, 8'h05, 8'hFF, 8'd1},
    {3'b100, 8'h00, 8'hFF, 8'd1},
    {3'b110, 8'h81, 8'hFF, 8'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hrd(output logic [7:0] d, input bit adv);
    @(negedge clk);
    host_addr = 2'd1; host_re = adv;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 0;
  endtask

  function automatic logic [7:0] txpat(input int row, input int k);
    return 8'(k * 7 + row * 3);
  endfunction
  function automatic logic [7:0] rxpat(input int row, input int k);
    return 8'(k * 13 + row * 5 + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq", irq, 0);
    chk(eng_req == 0, "R1 eng_req", eng_req, 0);
    hwr(2'd0, 8'h00);
    hrd(d, 0);
    chk(d == 8'h00, "R1 count", d, 0);

    for (int r = 0; r < 13; r++) begin
      logic rx, bm, ba;
      logic [7:0] cw, nk, en, expc;
      {rx, bm, ba, cw, nk, en} = TV[r];
      hwr(2'd0, 8'h01);
      for (int k = 0; k < 68; k++) hwr(2'd1, txpat(r, k));
      hwr(2'd0, 8'h00);
      hwr(2'd1, cw);
      hwr(2'd2, {3'b000, ba, 1'b0, bm, rx, 1'b1});
      if (en == 0) chk(irq == 1, "R2 immediate irq", irq, 1);
      for (int k = 0; k < int'(en); k++) begin
        chk(eng_req == 1, "R3 eng_req during transfer", eng_req, 1);
        if (!rx) begin
          // R10 pointer restarts at entry 0 each launch; R8 byte mode uses entry 0
          chk(eng_tx_byte == txpat(r, k), "R3 tx byte order", eng_tx_byte, txpat(r, k));
        end else begin
          logic ea;
          ea = !bm ? ba : (k == int'(cw[6:0]) - 1) ? !cw[7] : 1'b1;
          chk(eng_ack == ea, (k == int'(en) - 1) ? "R6 final ack" : "R5 ack", eng_ack, ea);
        end
        eng_done = 1; eng_nack = (k == int'(nk)); eng_rx_byte = rxpat(r, k);
        @(negedge clk);
        eng_done = 0; eng_nack = 0;
      end
      chk(eng_req == 0, "R3 eng_req end", eng_req, 0);
      chk(irq == 1, "R3 irq end", irq, 1);
      expc = (!bm || en == 0) ? cw : {cw[7], en[6:0]};
      hrd(d, 0);
      chk(d == expc, nk != 8'hFF ? "R4 count after nack" : bm ? "R5 count" : "R8 count unchanged", d, expc);
      if (rx && en != 0) begin
        hwr(2'd0, 8'h01);
        for (int k = 0; k < int'(en); k++) begin
          hrd(d, 1);
          chk(d == rxpat(r, k), "R5 stored byte", d, rxpat(r, k));
        end
      end
      hwr(2'd2, 8'h08);
      chk(irq == 0, "R7 irq cleared", irq, 0);
    end

    // R7 launch refused while interrupt pending
    hwr(2'd0, 8'h00);
    hwr(2'd1, 8'h00);
    hwr(2'd2, 8'h05);
    chk(irq == 1, "R2 zero count irq", irq, 1);
    hwr(2'd1, 8'h03);
    hwr(2'd2, 8'h05);
    chk(eng_req == 0, "R7 refused launch", eng_req, 0);
    repeat (3) @(negedge clk);
    chk(irq == 1, "R7 irq held", irq, 1);
    hwr(2'd2, 8'h08);
    chk(irq == 0, "R7 cleared", irq, 0);

    // R9 data port wrap after entry 67
    hwr(2'd0, 8'h01);
    for (int k = 0; k < 69; k++) hwr(2'd1, 8'(8'h40 + k));
    hwr(2'd0, 8'h01);
    hrd(d, 1);
    chk(d == 8'h84, "R9 wrap entry0", d, 8'h84);
    hrd(d, 1);
    chk(d == 8'h41, "R9 autoinc entry1", d, 8'h41);
    hwr(2'd0, 8'h00);
    chk(host_rdata == 8'h00 || host_addr == 2'd2, "R9 index readback", 0, 0);
    hrd(d, 0);
    chk(d == 8'h03, "R9 count via index 0", d, 8'h03);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule